// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared snooping bus. When a write lands on data that other caches also hold, the controller does not invalidate those copies. It broadcasts the new word so that every other holder patches its own copy. Each line holds one data word. A resident line is always in one of four states: `LN_EXCL` (the only clean copy), `LN_SHCLN` (clean, other copies exist), `LN_SHMOD` (other copies may exist, this cache wrote last, memory is stale) or `LN_MOD` (the only copy, dirty). There is no invalid state. A line that has never been filled, or whose tag differs from the request, counts as a miss.

The processor side takes one request at a time and gives one reply, with a miss flag. The controller sequence runs through `FS_IDLE` (accept a request and look up the line), `FS_EVICT` (write back a dirty victim), `FS_FILL` (read the word on the bus), `FS_BCAST` (broadcast a written word) and `FS_REPLY` (answer the processor). Its transitions are:

- `FS_IDLE` goes to `FS_REPLY` on a read hit or on a write hit to an exclusive or modified line.
- `FS_IDLE` goes to `FS_BCAST` on a write hit to a shared line.
- `FS_IDLE` goes to `FS_EVICT` on a miss whose victim is dirty.
- `FS_IDLE` goes to `FS_FILL` on any other miss.
- `FS_EVICT` goes to `FS_FILL` when its request is granted.
- `FS_FILL` goes to `FS_BCAST` on a shared write miss, and to `FS_REPLY` otherwise.
- `FS_BCAST` goes to `FS_REPLY` when its request is granted.
- `FS_REPLY` goes back to `FS_IDLE`.

The snoop side works on its own. It reacts in the same cycle to transactions that other caches place on the bus. It drives the wired-OR shared line, and it supplies flush data for dirty lines.

Top module: `dragon_ctrl`

## Requirements
- R1: After reset no line is resident. `cpu_req_ready` is 1, no bus request and no reply are driven, a snoop raises neither `snp_shared` nor `snp_flush`, and the first access to any address misses.
- R2: A read miss issues one bus read (command 1) at the request address. It then replies with miss flag 1 and the word from `bus_rdata`. The line is installed shared-clean if `bus_shared` was 1 at the grant, and exclusive otherwise.
- R3: A write miss issues a bus read. If `bus_shared` was 1, the read is followed by a bus update (command 2) carrying the written word, and the line ends shared-modified. If `bus_shared` was 0, no further transaction follows and the line ends modified. The reply carries miss flag 1 and the written word.
- R4: A write hit on an exclusive or modified line completes with no bus transaction, and the line ends modified.
- R5: A write hit on a shared-clean or shared-modified line issues a bus update with the full address and the written word. The line ends shared-modified if `bus_shared` was 1 at the grant, and modified otherwise.
- R6: A read hit in any state replies with miss flag 0 and the stored word, with no bus transaction. A reply lasts exactly one cycle.
- R7: A snooped update (command 2) that matches a shared-clean or shared-modified line writes `snp_data` into the line, and the line becomes shared-clean.
- R8: A snooped read (command 1) that matches a modified or shared-modified line raises `snp_flush` with the stored word on `snp_flush_data` in the same cycle, and the line becomes or stays shared-modified.
- R9: A snooped read that matches an exclusive line moves it to shared-clean, and a snooped read on a shared-clean line leaves it shared-clean. Neither one flushes.
- R10: `snp_shared` is 1 exactly when a snooped read or update matches the tag of a resident line. A snoop with a different tag, or with command 3, changes nothing.
- R11: A miss whose victim line is modified or shared-modified first issues a writeback (command 3) carrying the victim's address and word, then the bus read.
- R12: Line index is the low `IDXW` address bits and tag is the remaining upper bits. Bus and snoop commands are encoded as 0 none, 1 read, 2 update, 3 writeback.
- R13: A bus request keeps its command, address and data stable until `bus_gnt`. No bus request or reply is driven while `cpu_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 write, 0 read |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Word to write |
| cpu_req_ready | output | 1 | Request accepted this cycle if valid |
| cpu_resp_valid | output | 1 | Reply present (one cycle) |
| cpu_resp_miss | output | 1 | Request missed |
| cpu_resp_rdata | output | DW | Line word after the operation |
| bus_req_valid | output | 1 | Bus request present |
| bus_req_cmd | output | 2 | Bus command (R12) |
| bus_req_addr | output | AW | Bus address |
| bus_req_data | output | DW | Update or writeback word |
| bus_gnt | input | 1 | Request completes this cycle |
| bus_shared | input | 1 | Wired-OR shared line, valid with grant |
| bus_rdata | input | DW | Read data, valid with grant |
| snp_valid | input | 1 | Foreign transaction on the bus |
| snp_cmd | input | 2 | Its command (R12) |
| snp_addr | input | AW | Its address |
| snp_data | input | DW | Its update word |
| snp_shared | output | 1 | This cache holds the line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DW | Flushed word |

## Verification
The bench builds the controller with the default parameters: 8-bit addresses, 16-bit words and a 2-bit index, which gives four lines. With only four lines, addresses such as 0x10 and 0x14 fall on the same line under different tags. This makes victim writebacks, tag-mismatched snoops and replacement reachable within a few operations. Every state is identified from the ports alone, either by the bus traffic that a later write causes or by the snoop response a probe draws. Grants are also held back for some cycles so that request stability can be observed.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

    typedef enum logic [1:0] {
        LN_EXCL  = 2'd0,
        LN_SHCLN = 2'd1,
        LN_SHMOD = 2'd2,
        LN_MOD   = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_READ   = 2'd1,
        BC_UPDATE = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_EVICT,
        FS_FILL,
        FS_BCAST,
        FS_REPLY
    } fsm_e;

endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
    import dragon_pkg::*;
#(
    parameter int IDXW = 2,
    parameter int TAGW = 6,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    // lookup port for the request sequencer
    input  logic [IDXW-1:0] a_idx,
    output logic            a_present,
    output logic [TAGW-1:0] a_tag,
    output line_st_e        a_st,
    output logic [DW-1:0]   a_data,
    // lookup port for the snoop side
    input  logic [IDXW-1:0] b_idx,
    output logic            b_present,
    output logic [TAGW-1:0] b_tag,
    output line_st_e        b_st,
    output logic [DW-1:0]   b_data,
    // snoop update port
    input  logic            s_we,
    input  logic [IDXW-1:0] s_idx,
    input  line_st_e        s_st,
    input  logic            s_dwe,
    input  logic [DW-1:0]   s_data,
    // sequencer install / update port (wins on collision)
    input  logic            f_we,
    input  logic [IDXW-1:0] f_idx,
    input  logic [TAGW-1:0] f_tag,
    input  line_st_e        f_st,
    input  logic            f_dwe,
    input  logic [DW-1:0]   f_data
);
    localparam int LINES = 1 << IDXW;

    logic            present_q [LINES];
    logic [TAGW-1:0] tag_q     [LINES];
    line_st_e        st_q      [LINES];
    logic [DW-1:0]   data_q    [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                present_q[i] <= 1'b0;
                tag_q[i]     <= '0;
                st_q[i]      <= LN_EXCL;
                data_q[i]    <= '0;
            end
        end else begin
            if (s_we) begin
                st_q[s_idx] <= s_st;
                if (s_dwe) data_q[s_idx] <= s_data;
            end
            if (f_we) begin
                present_q[f_idx] <= 1'b1;
                tag_q[f_idx]     <= f_tag;
                st_q[f_idx]      <= f_st;
                if (f_dwe) data_q[f_idx] <= f_data;
            end
        end
    end

    assign a_present = present_q[a_idx];
    assign a_tag     = tag_q[a_idx];
    assign a_st      = st_q[a_idx];
    assign a_data    = data_q[a_idx];
    assign b_present = present_q[b_idx];
    assign b_tag     = tag_q[b_idx];
    assign b_st      = st_q[b_idx];
    assign b_data    = data_q[b_idx];

endmodule

// File: rtl/dragon_snoop.sv
module dragon_snoop
    import dragon_pkg::*;
#(
    parameter int TAGW = 6,
    parameter int DW   = 16
) (
    input  logic            snp_valid,
    input  bus_cmd_e        snp_cmd,
    input  logic [TAGW-1:0] snp_tag,
    input  logic [DW-1:0]   snp_data,
    input  logic            line_present,
    input  logic [TAGW-1:0] line_tag,
    input  line_st_e        line_st,
    input  logic [DW-1:0]   line_data,
    output logic            shared,
    output logic            flush,
    output logic [DW-1:0]   flush_data,
    output logic            we,
    output line_st_e        new_st,
    output logic            dwe,
    output logic [DW-1:0]   new_data
);
    logic match;
    logic dirty;

    assign match      = snp_valid && line_present && (line_tag == snp_tag);
    assign dirty      = (line_st == LN_MOD) || (line_st == LN_SHMOD);
    assign flush_data = line_data;
    assign new_data   = snp_data;

    always_comb begin
        shared = 1'b0;
        flush  = 1'b0;
        we     = 1'b0;
        dwe    = 1'b0;
        new_st = line_st;
        if (match) begin
            unique case (snp_cmd)
                BC_READ: begin
                    shared = 1'b1;
                    flush  = dirty;
                    we     = 1'b1;
                    unique case (line_st)
                        LN_EXCL:  new_st = LN_SHCLN;
                        LN_MOD:   new_st = LN_SHMOD;
                        LN_SHCLN: new_st = LN_SHCLN;
                        LN_SHMOD: new_st = LN_SHMOD;
                    endcase
                end
                BC_UPDATE: begin
                    shared = 1'b1;
                    if ((line_st == LN_SHCLN) || (line_st == LN_SHMOD)) begin
                        we     = 1'b1;
                        dwe    = 1'b1;
                        new_st = LN_SHCLN;
                    end
                end
                BC_NONE, BC_WRBACK: begin
                    shared = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
    import dragon_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int IDXW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_req_ready,
    output logic          cpu_resp_valid,
    output logic          cpu_resp_miss,
    output logic [DW-1:0] cpu_resp_rdata,
    output logic          bus_req_valid,
    output logic [1:0]    bus_req_cmd,
    output logic [AW-1:0] bus_req_addr,
    output logic [DW-1:0] bus_req_data,
    input  logic          bus_gnt,
    input  logic          bus_shared,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    output logic          snp_shared,
    output logic          snp_flush,
    output logic [DW-1:0] snp_flush_data
);
    localparam int TAGW = AW - IDXW;

    fsm_e            state_q, state_d;
    logic            req_write_q;
    logic [AW-1:0]   req_addr_q;
    logic [DW-1:0]   req_wdata_q;
    logic            miss_q;
    logic            accept;
    bus_cmd_e        cmd;

    logic [IDXW-1:0] cur_idx;
    logic [TAGW-1:0] cur_tag;
    logic            a_present, b_present;
    logic [TAGW-1:0] a_tag, b_tag;
    line_st_e        a_st, b_st;
    logic [DW-1:0]   a_data, b_data;
    logic            hit, victim_dirty;

    logic            s_we, s_dwe;
    line_st_e        s_st;
    logic [DW-1:0]   s_data;
    logic            f_we, f_dwe;
    line_st_e        f_st;
    logic [DW-1:0]   f_data;

    assign cur_idx = (state_q == FS_IDLE) ? cpu_req_addr[IDXW-1:0]  : req_addr_q[IDXW-1:0];
    assign cur_tag = (state_q == FS_IDLE) ? cpu_req_addr[AW-1:IDXW] : req_addr_q[AW-1:IDXW];
    assign hit          = a_present && (a_tag == cur_tag);
    assign victim_dirty = a_present && ((a_st == LN_MOD) || (a_st == LN_SHMOD));

    dragon_line_store #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (cur_idx),
        .a_present(a_present),
        .a_tag    (a_tag),
        .a_st     (a_st),
        .a_data   (a_data),
        .b_idx    (snp_addr[IDXW-1:0]),
        .b_present(b_present),
        .b_tag    (b_tag),
        .b_st     (b_st),
        .b_data   (b_data),
        .s_we     (s_we),
        .s_idx    (snp_addr[IDXW-1:0]),
        .s_st     (s_st),
        .s_dwe    (s_dwe),
        .s_data   (s_data),
        .f_we     (f_we),
        .f_idx    (cur_idx),
        .f_tag    (cur_tag),
        .f_st     (f_st),
        .f_dwe    (f_dwe),
        .f_data   (f_data)
    );

    dragon_snoop #(.TAGW(TAGW), .DW(DW)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (bus_cmd_e'(snp_cmd)),
        .snp_tag     (snp_addr[AW-1:IDXW]),
        .snp_data    (snp_data),
        .line_present(b_present),
        .line_tag    (b_tag),
        .line_st     (b_st),
        .line_data   (b_data),
        .shared      (snp_shared),
        .flush       (snp_flush),
        .flush_data  (snp_flush_data),
        .we          (s_we),
        .new_st      (s_st),
        .dwe         (s_dwe),
        .new_data    (s_data)
    );

    // state and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= FS_IDLE;
            req_write_q <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            miss_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_write_q <= cpu_req_write;
                req_addr_q  <= cpu_req_addr;
                req_wdata_q <= cpu_req_wdata;
                miss_q      <= !hit;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d        = state_q;
        accept         = 1'b0;
        cpu_req_ready  = 1'b0;
        cpu_resp_valid = 1'b0;
        bus_req_valid  = 1'b0;
        cmd            = BC_NONE;
        bus_req_addr   = req_addr_q;
        bus_req_data   = req_wdata_q;
        f_we           = 1'b0;
        f_dwe          = 1'b0;
        f_st           = LN_MOD;
        f_data         = req_wdata_q;
        unique case (state_q)
            FS_IDLE: begin
                cpu_req_ready = !snp_valid;
                if (cpu_req_valid && !snp_valid) begin
                    accept = 1'b1;
                    if (hit) begin
                        if (!cpu_req_write) begin
                            state_d = FS_REPLY;
                        end else if ((a_st == LN_EXCL) || (a_st == LN_MOD)) begin
                            f_we    = 1'b1;
                            f_dwe   = 1'b1;
                            f_st    = LN_MOD;
                            f_data  = cpu_req_wdata;
                            state_d = FS_REPLY;
                        end else begin
                            state_d = FS_BCAST;
                        end
                    end else begin
                        state_d = victim_dirty ? FS_EVICT : FS_FILL;
                    end
                end
            end
            FS_EVICT: begin
                bus_req_valid = 1'b1;
                cmd           = BC_WRBACK;
                bus_req_addr  = {a_tag, cur_idx};
                bus_req_data  = a_data;
                if (bus_gnt) state_d = FS_FILL;
            end
            FS_FILL: begin
                bus_req_valid = 1'b1;
                cmd           = BC_READ;
                bus_req_data  = '0;
                if (bus_gnt) begin
                    f_we  = 1'b1;
                    f_dwe = 1'b1;
                    if (req_write_q && bus_shared) begin
                        f_st    = LN_SHCLN;
                        f_data  = bus_rdata;
                        state_d = FS_BCAST;
                    end else if (req_write_q) begin
                        f_st    = LN_MOD;
                        f_data  = req_wdata_q;
                        state_d = FS_REPLY;
                    end else begin
                        f_st    = bus_shared ? LN_SHCLN : LN_EXCL;
                        f_data  = bus_rdata;
                        state_d = FS_REPLY;
                    end
                end
            end
            FS_BCAST: begin
                bus_req_valid = 1'b1;
                cmd           = BC_UPDATE;
                if (bus_gnt) begin
                    f_we    = 1'b1;
                    f_dwe   = 1'b1;
                    f_st    = bus_shared ? LN_SHMOD : LN_MOD;
                    state_d = FS_REPLY;
                end
            end
            FS_REPLY: begin
                cpu_resp_valid = 1'b1;
                state_d        = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    assign bus_req_cmd    = cmd;
    assign cpu_resp_miss  = miss_q;
    assign cpu_resp_rdata = a_data;

endmodule

// File: rtl/dragon_ctrl_chk.sv
module dragon_ctrl_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req_ready,
    input logic          cpu_resp_valid,
    input logic          bus_req_valid,
    input logic [1:0]    bus_req_cmd,
    input logic [AW-1:0] bus_req_addr,
    input logic [DW-1:0] bus_req_data,
    input logic          bus_gnt,
    input logic          snp_valid,
    input logic [1:0]    snp_cmd,
    input logic          snp_shared,
    input logic          snp_flush
);
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_gnt) |=> (bus_req_valid && $stable(bus_req_cmd)
                                         && $stable(bus_req_addr) && $stable(bus_req_data)));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_ready |-> (!bus_req_valid && !cpu_resp_valid));

    p_reply_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid);

    p_wb_then_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_gnt && bus_req_cmd == 2'd3) |=> (bus_req_valid && bus_req_cmd == 2'd1));

    p_update_then_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_gnt && bus_req_cmd == 2'd2) |=> cpu_resp_valid);

    p_flush_with_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_shared);

    p_shared_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

endmodule

bind dragon_ctrl dragon_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_ready (cpu_req_ready),
    .cpu_resp_valid(cpu_resp_valid),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .bus_req_addr  (bus_req_addr),
    .bus_req_data  (bus_req_data),
    .bus_gnt       (bus_gnt),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_shared    (snp_shared),
    .snp_flush     (snp_flush)
);

// File: tb/tb_dragon_ctrl.sv
`timescale 1ns/1ps
module tb_dragon_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IDXW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready, cpu_resp_valid, cpu_resp_miss;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_data;
    logic          bus_gnt = 1'b0, bus_shared = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared, snp_flush;
    logic [DW-1:0] snp_flush_data;

    always #2.5 clk = ~clk;

    dragon_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW)) dut (.*);

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";

    // scoreboard queues
    logic          q_miss  [$];
    logic [DW-1:0] q_rdata [$];
    string         q_rtag  [$];
    logic [1:0]    q_cmd   [$];
    logic [AW-1:0] q_addr  [$];
    logic [DW-1:0] q_bdata [$];
    bit            q_chk   [$];
    string         q_btag  [$];

    logic [DW-1:0] mem [1 << AW];
    logic          share_next = 1'b0;
    int            gnt_delay = 0, wait_cnt = 0, bus_cnt = 0;
    logic [1:0]    last_cmd;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    task automatic check(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // bus model: memory, grant, expected transaction compare
    always @(negedge clk) begin
        bus_gnt = 1'b0;
        if (rst_n && bus_req_valid) begin
            if (wait_cnt > 0)
                check(bus_req_cmd == last_cmd && bus_req_addr == last_addr && bus_req_data == last_data,
                      "R13", "request held until grant",
                      {6'd0, bus_req_cmd, bus_req_addr, bus_req_data}, {6'd0, last_cmd, last_addr, last_data});
            last_cmd  = bus_req_cmd;
            last_addr = bus_req_addr;
            last_data = bus_req_data;
            if (wait_cnt < gnt_delay) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                bus_cnt++;
                if (q_cmd.size() == 0) begin
                    check(1'b0, cur_req, "unexpected bus request", 32'(bus_req_cmd), 32'd0);
                end else begin
                    logic [1:0] ec; logic [AW-1:0] ea; logic [DW-1:0] ed; bit chk; string bt;
                    ec = q_cmd.pop_front(); ea = q_addr.pop_front(); ed = q_bdata.pop_front();
                    chk = q_chk.pop_front(); bt = q_btag.pop_front();
                    check(bus_req_cmd == ec && bus_req_addr == ea, bt, "bus cmd/addr",
                          32'({bus_req_cmd, bus_req_addr}), 32'({ec, ea}));
                    if (chk) check(bus_req_data == ed, bt, "bus data", 32'(bus_req_data), 32'(ed));
                end
                if (bus_req_cmd == 2'd3) mem[bus_req_addr] = bus_req_data;
                bus_rdata  = mem[bus_req_addr];
                bus_shared = share_next;
                bus_gnt    = 1'b1;
            end
        end
    end

    // reply monitor
    always @(negedge clk) begin
        if (rst_n && cpu_resp_valid) begin
            if (q_miss.size() == 0) begin
                check(1'b0, cur_req, "unexpected reply", 32'(cpu_resp_rdata), 32'd0);
            end else begin
                logic em; logic [DW-1:0] ed; string rt;
                em = q_miss.pop_front(); ed = q_rdata.pop_front(); rt = q_rtag.pop_front();
                check(cpu_resp_miss == em, rt, "reply miss flag", 32'(cpu_resp_miss), 32'(em));
                check(cpu_resp_rdata == ed, rt, "reply data", 32'(cpu_resp_rdata), 32'(ed));
            end
        end
    end

    task automatic exp_bus(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d, bit chk, string r);
        q_cmd.push_back(c); q_addr.push_back(a); q_bdata.push_back(d);
        q_chk.push_back(chk); q_btag.push_back(r);
    endtask

    task automatic cpu_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                          bit e_miss, logic [DW-1:0] e_data, int n_bus, string r);
        int start;
        cur_req = r;
        start = bus_cnt;
        q_miss.push_back(e_miss); q_rdata.push_back(e_data); q_rtag.push_back(r);
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_req_ready || q_miss.size() != 0) @(negedge clk);
        check(bus_cnt - start == n_bus, r, "bus transaction count", 32'(bus_cnt - start), 32'(n_bus));
        check(q_cmd.size() == 0, r, "expected bus transactions left", 32'(q_cmd.size()), 32'd0);
    endtask

    task automatic snoop(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d,
                         bit e_sh, bit e_fl, logic [DW-1:0] e_fd, string r);
        cur_req = r;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_data = d;
        #1;
        check(snp_shared == e_sh, r, "snoop shared", 32'(snp_shared), 32'(e_sh));
        check(snp_flush == e_fl, r, "snoop flush", 32'(snp_flush), 32'(e_fl));
        if (e_fl) check(snp_flush_data == e_fd, r, "flush data", 32'(snp_flush_data), 32'(e_fd));
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 3 + 100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 32'd1);
        check(bus_req_valid == 1'b0, "R1", "no bus request after reset", 32'(bus_req_valid), 32'd0);
        check(cpu_resp_valid == 1'b0, "R1", "no reply after reset", 32'(cpu_resp_valid), 32'd0);
        snoop(2'd1, 8'h10, 16'h0, 1'b0, 1'b0, 16'h0, "R1");

        // R2 read miss, not shared -> exclusive; R12 index/tag and command codes
        share_next = 1'b0;
        exp_bus(2'd1, 8'h10, 16'h0, 1'b0, "R12");
        cpu_op(1'b0, 8'h10, 16'h0, 1'b1, mem[8'h10], 1, "R2");
        // R4 write hit exclusive -> modified, no bus
        cpu_op(1'b1, 8'h10, 16'h1111, 1'b0, 16'h1111, 0, "R4");
        // R8 snooped read on modified flushes, then shared-modified still flushes
        snoop(2'd1, 8'h10, 16'h0, 1'b1, 1'b1, 16'h1111, "R8");
        snoop(2'd1, 8'h10, 16'h0, 1'b1, 1'b1, 16'h1111, "R8");
        // R7 snooped update patches and makes shared-clean (no flush after)
        snoop(2'd2, 8'h10, 16'h2222, 1'b1, 1'b0, 16'h0, "R7");
        snoop(2'd1, 8'h10, 16'h0, 1'b1, 1'b0, 16'h0, "R7");
        // R6 read hit returns patched word
        cpu_op(1'b0, 8'h10, 16'h0, 1'b0, 16'h2222, 0, "R6");
        // R5 write hit shared-clean, shared -> update, shared-modified
        share_next = 1'b1;
        exp_bus(2'd2, 8'h10, 16'h3333, 1'b1, "R5");
        cpu_op(1'b1, 8'h10, 16'h3333, 1'b0, 16'h3333, 1, "R5");
        snoop(2'd1, 8'h10, 16'h0, 1'b1, 1'b1, 16'h3333, "R5");
        // R5 write hit shared-modified, not shared -> modified (next write is silent)
        share_next = 1'b0;
        exp_bus(2'd2, 8'h10, 16'h4444, 1'b1, "R5");
        cpu_op(1'b1, 8'h10, 16'h4444, 1'b0, 16'h4444, 1, "R5");
        cpu_op(1'b1, 8'h10, 16'h5555, 1'b0, 16'h5555, 0, "R5");
        // R11 dirty victim written back before fill; grants delayed for R13
        share_next = 1'b1;
        gnt_delay = 2;
        exp_bus(2'd3, 8'h10, 16'h5555, 1'b1, "R11");
        exp_bus(2'd1, 8'h14, 16'h0, 1'b0, "R11");
        cpu_op(1'b0, 8'h14, 16'h0, 1'b1, mem[8'h14], 2, "R11");
        gnt_delay = 0;
        check(mem[8'h10] == 16'h5555, "R11", "memory after writeback", 32'(mem[8'h10]), 32'h5555);
        // R10 replaced tag no longer answers
        snoop(2'd1, 8'h10, 16'h0, 1'b0, 1'b0, 16'h0, "R10");
        // R2 shared read miss installed shared-clean: write hit broadcasts
        share_next = 1'b0;
        exp_bus(2'd2, 8'h14, 16'h6666, 1'b1, "R2");
        cpu_op(1'b1, 8'h14, 16'h6666, 1'b0, 16'h6666, 1, "R2");
        // R9 exclusive line snooped by read becomes shared-clean without flush
        exp_bus(2'd1, 8'h01, 16'h0, 1'b0, "R2");
        cpu_op(1'b0, 8'h01, 16'h0, 1'b1, mem[8'h01], 1, "R2");
        snoop(2'd1, 8'h01, 16'h0, 1'b1, 1'b0, 16'h0, "R9");
        exp_bus(2'd2, 8'h01, 16'h0AAA, 1'b1, "R9");
        cpu_op(1'b1, 8'h01, 16'h0AAA, 1'b0, 16'h0AAA, 1, "R9");
        // R3 shared write miss: writeback, read, update -> shared-modified
        share_next = 1'b1;
        exp_bus(2'd3, 8'h01, 16'h0AAA, 1'b1, "R11");
        exp_bus(2'd1, 8'h21, 16'h0, 1'b0, "R3");
        exp_bus(2'd2, 8'h21, 16'h7777, 1'b1, "R3");
        cpu_op(1'b1, 8'h21, 16'h7777, 1'b1, 16'h7777, 3, "R3");
        snoop(2'd1, 8'h21, 16'h0, 1'b1, 1'b1, 16'h7777, "R3");
        // R3 unshared write miss: read only -> modified (next write silent)
        share_next = 1'b0;
        exp_bus(2'd1, 8'h22, 16'h0, 1'b0, "R3");
        cpu_op(1'b1, 8'h22, 16'h8888, 1'b1, 16'h8888, 1, "R3");
        cpu_op(1'b1, 8'h22, 16'h9999, 1'b0, 16'h9999, 0, "R3");
        // R10 mismatched tag and writeback command ignored
        share_next = 1'b1;
        exp_bus(2'd1, 8'h23, 16'h0, 1'b0, "R2");
        cpu_op(1'b0, 8'h23, 16'h0, 1'b1, mem[8'h23], 1, "R2");
        snoop(2'd2, 8'h27, 16'hBEEF, 1'b0, 1'b0, 16'h0, "R10");
        snoop(2'd3, 8'h23, 16'hBEEF, 1'b0, 1'b0, 16'h0, "R10");
        cpu_op(1'b0, 8'h23, 16'h0, 1'b0, mem[8'h23], 0, "R10");
        // R7 update on shared-clean line patches the word
        snoop(2'd2, 8'h23, 16'h1234, 1'b1, 1'b0, 16'h0, "R7");
        cpu_op(1'b0, 8'h23, 16'h0, 1'b0, 16'h1234, 0, "R7");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule